// File: doc/BRIEF.md
# Identification Page Store with One-Way Lock

This block holds a small extra page of non-volatile bytes kept beside the main memory array of a two-wire serial memory. A bus controller, which already handles bit timing and Start/Stop detection, passes each decoded byte-level event to it. These events are an address phase, a received data byte, a read request, and Start and Stop pulses. Each event carries the four-bit device-type nibble of the current transaction. The block answers only events whose nibble is 1011. For each such event it returns a registered acknowledge decision and, for read requests, the data byte.

Page writes are collected in a staging buffer and take effect only at Stop, after a programming interval. The lock command uses the same interval to set a flag that no command can clear. Once the flag is set, data bytes of page writes are refused. This refusal is also how software probes the lock state: it sends one data byte and then a Start, so nothing is programmed.

Top module: `idpage_ctl`

## Requirements
- R1: After the power-on reset `rst_n`, `busy`, `locked` and `rsp_valid` are 0. Every page byte reads 0xFF.
- R2: An event whose `req_type` is not 1011 gives no response (`rsp_valid` stays 0) and changes no state.
- R3: `req_kind` encodes 0 = address phase, 1 = write data byte, 2 = read request. A matching event gets `rsp_valid`=1 one cycle later. An address phase is acknowledged and loads the byte pointer from `req_addr[4:0]`. Address bit 10 selects the session: 0 is a page write and 1 is a lock command. All other address bits are ignored.
- R4: In a page-write session on an unlocked page, each data byte is acknowledged and staged at the pointer, and the pointer then advances, wrapping from 31 to 0. Staged bytes reach the page only when Stop is followed by the programming interval.
- R5: A Stop that closes a session with work to do drives `busy` high for exactly `PROG_CYCLES` cycles. Every matching event during that time is not acknowledged, and `busy` rises only after a Stop.
- R6: A lock-session data byte is always acknowledged. If its bit 1 is 1, `locked` becomes 1 when the programming interval ends. If bit 1 is 0, nothing is programmed and `locked` is unchanged.
- R7: While `locked` is 1, page-write data bytes are not acknowledged and the page contents stay unchanged.
- R8: A Start that follows staged data bytes discards them. The Stop that follows starts no programming. The acknowledge given to the single probe byte reports the lock state (1 = unlocked).
- R9: Read requests return the byte at the pointer and advance the pointer, wrapping from byte 31 to byte 0. A Start between the address phase and the reads keeps the pointer.
- R10: Once `locked` is 1, it stays 1 until `rst_n` is asserted.
- R11: A Stop that closes a session with nothing staged and no lock armed leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; restores a fresh part |
| bus_start | input | 1 | One-cycle pulse: Start or repeated Start seen |
| bus_stop | input | 1 | One-cycle pulse: Stop seen |
| req_valid | input | 1 | Event strobe |
| req_kind | input | 2 | 0 address phase, 1 write data byte, 2 read request |
| req_type | input | 4 | Device-type nibble of the current transaction |
| req_addr | input | ADDR_W | Word address, used with the address phase |
| req_data | input | 8 | Data byte, used with write data |
| rsp_valid | output | 1 | Response present, one cycle after a matching strobe |
| rsp_ack | output | 1 | 1 = acknowledge the byte, 0 = no acknowledge |
| rsp_data | output | 8 | Read byte, meaningful for read requests |
| busy | output | 1 | Programming interval running |
| locked | output | 1 | Page is permanently read-only |

## Verification
The bench builds the block with a 32-byte page and `PROG_CYCLES` set to 20, not the long default. At that setting the whole programming interval can be counted cycle by cycle, so its exact length can be checked. A request can also be placed inside the interval, and several program, lock and probe rounds fit in a short run. The page size is a power of two at the usual value, so the runs reach both the pointer wrap in page writes and the wrap in reads.

// File: rtl/idpage_pkg.sv
// Shared encodings for the identification page block.
// Assumes the controller presents one decoded event per strobe.
package idpage_pkg;

    // Event kinds presented by the bus controller
    typedef enum logic [1:0] {
        REQ_ADDR  = 2'd0,
        REQ_WDATA = 2'd1,
        REQ_RDATA = 2'd2,
        REQ_NONE  = 2'd3
    } req_kind_e;

    // Session selected by the latest address phase
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_PAGE = 2'd1,
        MODE_LOCK = 2'd2
    } sess_mode_e;

endpackage

// File: rtl/idpage_store.sv
// Page storage plus staging buffer.
// The page bytes reset to the erased value only on power-on reset.
// Staged bytes move to the page on the commit pulse, and only for
// positions marked in the mask. Assumes clr and commit never coincide
// with a staging write.
module idpage_store #(
    parameter int PAGE_BYTES = 32,
    parameter int IDX_W      = 5,
    parameter logic [7:0] ERASED = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic             clr,
    input  logic             commit,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rbyte
);

    logic [7:0] page_q  [PAGE_BYTES];
    logic [7:0] stage_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
        // Stage one byte and mark it pending
        always_ff @(posedge clk) begin
            if (!rst_n || clr || commit) begin
                mask_q[i] <= 1'b0;
            end else if (we && widx == IDX_W'(i)) begin
                mask_q[i]  <= 1'b1;
                stage_q[i] <= wdata;
            end
        end

        // Program the byte when its staged copy is committed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_q[i] <= ERASED;
            end else if (commit && mask_q[i]) begin
                page_q[i] <= stage_q[i];
            end
        end
    end

    // Read port
    always_comb rbyte = page_q[ridx];

endmodule

// File: rtl/idpage_prog.sv
// Programming timer and permanent lock flag.
// A start pulse arms a down-counter for PROG_CYCLES cycles. On the
// last cycle it issues commit and, if the lock was armed, sets the flag.
// Only rst_n clears the flag. Assumes PROG_CYCLES >= 1.
module idpage_prog #(
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic lock_arm,
    output logic busy,
    output logic commit,
    output logic locked
);

    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             arm_q;
    logic             lock_q;

    // Count down the programming interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start && cnt_q == '0) begin
            cnt_q <= CNT_W'(PROG_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Remember whether this interval programs the lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (start && cnt_q == '0) begin
            arm_q <= lock_arm;
        end
    end

    // One-way lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (commit && arm_q) begin
            lock_q <= 1'b1;
        end
    end

    always_comb begin
        busy   = (cnt_q != '0);
        commit = (cnt_q == CNT_W'(1));
        locked = lock_q;
    end

endmodule

// File: rtl/idpage_ctl.sv
// Identification page controller (top).
// Decodes controller events tagged with the page's device-type nibble and
// keeps the byte pointer and session mode. It stages page writes, arms
// the lock and answers each matching event one cycle later.
// Assumes at most one of bus_start, bus_stop, req_valid per cycle.
module idpage_ctl
    import idpage_pkg::*;
#(
    parameter int         PAGE_BYTES   = 32,
    parameter int         ADDR_W       = 16,
    parameter int         LOCK_SEL_BIT = 10,
    parameter int         LOCK_DAT_BIT = 1,
    parameter int         PROG_CYCLES  = 5000,
    parameter logic [3:0] ID_TYPE      = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [3:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              rsp_valid,
    output logic              rsp_ack,
    output logic [7:0]        rsp_data,
    output logic              busy,
    output logic              locked
);

    localparam int IDX_W = $clog2(PAGE_BYTES);

    req_kind_e        kind;
    sess_mode_e       mode_q;
    logic [IDX_W-1:0] ptr_q, ptr_nxt;
    logic             hit, go_addr, go_page, go_lock, go_rd, ack_now;
    logic             lock_arm_q, staged_q, commit_req, commit, stage_clr;
    logic [7:0]       rd_byte;

    // Decode a strobe into the action it performs
    always_comb begin
        kind     = req_kind_e'(req_kind);
        hit      = req_valid && (req_type == ID_TYPE);
        go_addr  = hit && !busy && kind == REQ_ADDR;
        go_page  = hit && !busy && kind == REQ_WDATA && mode_q == MODE_PAGE && !locked;
        go_lock  = hit && !busy && kind == REQ_WDATA && mode_q == MODE_LOCK;
        go_rd    = hit && !busy && kind == REQ_RDATA;
        ack_now  = go_addr || go_page || go_lock || go_rd;
        ptr_nxt  = (ptr_q == IDX_W'(PAGE_BYTES - 1)) ? '0 : ptr_q + 1'b1;
        stage_clr  = bus_start && !busy;
        commit_req = bus_stop && !busy &&
                     ((mode_q == MODE_PAGE && staged_q) || (mode_q == MODE_LOCK && lock_arm_q));
    end

    // Byte pointer inside the page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (go_addr) begin
            ptr_q <= req_addr[IDX_W-1:0];
        end else if (go_page || go_rd) begin
            ptr_q <= ptr_nxt;
        end
    end

    // Session mode, closed by any Start or Stop
    always_ff @(posedge clk) begin
        if (!rst_n || bus_start || bus_stop) begin
            mode_q <= MODE_IDLE;
        end else if (go_addr) begin
            mode_q <= req_addr[LOCK_SEL_BIT] ? MODE_LOCK : MODE_PAGE;
        end
    end

    // Session bookkeeping: staged page data and armed lock
    always_ff @(posedge clk) begin
        if (!rst_n || bus_start || bus_stop || go_addr) begin
            staged_q   <= 1'b0;
            lock_arm_q <= 1'b0;
        end else begin
            if (go_page) staged_q   <= 1'b1;
            if (go_lock) lock_arm_q <= req_data[LOCK_DAT_BIT];
        end
    end

    // Registered response to each matching event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ack   <= 1'b0;
            rsp_data  <= 8'h00;
        end else begin
            rsp_valid <= hit;
            rsp_ack   <= ack_now;
            rsp_data  <= go_rd ? rd_byte : 8'h00;
        end
    end

    idpage_store #(
        .PAGE_BYTES (PAGE_BYTES),
        .IDX_W      (IDX_W)
    ) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (go_page),
        .widx   (ptr_q),
        .wdata  (req_data),
        .clr    (stage_clr),
        .commit (commit),
        .ridx   (ptr_q),
        .rbyte  (rd_byte)
    );

    idpage_prog #(
        .PROG_CYCLES (PROG_CYCLES)
    ) prog_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (commit_req),
        .lock_arm (mode_q == MODE_LOCK && lock_arm_q),
        .busy     (busy),
        .commit   (commit),
        .locked   (locked)
    );

endmodule

// File: rtl/idpage_chk.sv
// Protocol checker for idpage_ctl, attached by bind.
// Observes ports and the session mode; drives nothing.
module idpage_chk
    import idpage_pkg::*;
#(
    parameter logic [3:0] ID_TYPE = 4'b1011
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_stop,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic [3:0] req_type,
    input logic       rsp_valid,
    input logic       rsp_ack,
    input logic       busy,
    input logic       locked,
    input sess_mode_e mode_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !locked && !rsp_valid));

    // R2
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type != ID_TYPE) |=> !rsp_valid);

    // R5
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && req_type == ID_TYPE) |=> (rsp_valid && !rsp_ack));

    // R5
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_stop));

    // R7
    locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && req_valid && req_type == ID_TYPE && req_kind == 2'd1 && mode_q == MODE_PAGE)
        |=> !rsp_ack);

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

endmodule

bind idpage_ctl idpage_chk #(.ID_TYPE(ID_TYPE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_stop  (bus_stop),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_type  (req_type),
    .rsp_valid (rsp_valid),
    .rsp_ack   (rsp_ack),
    .busy      (busy),
    .locked    (locked),
    .mode_q    (mode_q)
);

// File: tb/idpage_ctl_tb_top.sv
// Scoreboard bench: driver tasks queue expected responses, a monitor
// pops and compares them as responses appear.
module idpage_ctl_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         PROG       = 20;
    localparam logic [3:0] IDT        = 4'b1011;
    localparam logic [3:0] MAINT      = 4'b1010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0, req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd3;
    logic [3:0]  req_type = 4'd0;
    logic [15:0] req_addr = 16'd0;
    logic [7:0]  req_data = 8'd0;
    logic        rsp_valid, rsp_ack, busy, locked;
    logic [7:0]  rsp_data;

    typedef struct {
        logic       ack;
        logic [7:0] data;
        logic       chk_data;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] ref_mem [32];
    int         n_chk = 0, n_bad = 0, busy_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idpage_ctl #(.PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .req_valid(req_valid), .req_kind(req_kind), .req_type(req_type),
        .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .rsp_data(rsp_data), .busy(busy), .locked(locked)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each response against the queue head
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_ack === e.ack, {e.tag, " ack"}, 32'(rsp_ack), 32'(e.ack));
                if (e.chk_data)
                    check(rsp_data === e.data, {e.tag, " data"}, 32'(rsp_data), 32'(e.data));
            end
        end
        if (busy) busy_seen++;
    end

    // Driver: one event, called at a falling edge
    task automatic send(input logic [1:0] k, input logic [3:0] t, input logic [15:0] a,
                        input logic [7:0] d, input logic eack, input logic [7:0] edat,
                        input logic chkd, input string tag);
        if (t == IDT) exp_q.push_back('{eack, edat, chkd, tag});
        req_valid = 1'b1; req_kind = k; req_type = t; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd3;
    endtask

    task automatic pulse_start();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        busy_seen = 0;
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    // Address phase, repeated Start, then n reads compared with the model
    task automatic read_run(input int start, input int n, input string tag);
        send(2'd0, IDT, 16'(start), 8'h00, 1'b1, 8'h00, 1'b0, {tag, " addr"});
        pulse_start();
        for (int i = 0; i < n; i++)
            send(2'd2, IDT, 16'h0, 8'h00, 1'b1, ref_mem[(start + i) % 32], 1'b1, tag);
        pulse_stop();
        check(busy == 1'b0, "R11 read session stop leaves busy low", 32'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 32; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !locked && !rsp_valid, "R1 reset outputs", {busy, locked, rsp_valid}, 0);

        // R1 R9: erased page, read wraps from 30 through 31 to 0
        read_run(30, 3, "R9 erased read wrap");

        // R4 R3: page write from 30 with junk high bits, wraps to 0,1
        send(2'd0, IDT, 16'h201E, 8'h00, 1'b1, 8'h00, 1'b0, "R3 page addr");
        send(2'd1, IDT, 16'h0, 8'hA0, 1'b1, 8'h00, 1'b0, "R4 data0");
        send(2'd1, IDT, 16'h0, 8'hA1, 1'b1, 8'h00, 1'b0, "R4 data1");
        send(2'd1, IDT, 16'h0, 8'hA2, 1'b1, 8'h00, 1'b0, "R4 data2");
        send(2'd1, IDT, 16'h0, 8'hA3, 1'b1, 8'h00, 1'b0, "R4 data3");
        pulse_stop();
        check(busy == 1'b1, "R5 busy after commit stop", 32'(busy), 1);
        send(2'd0, IDT, 16'h0000, 8'h00, 1'b0, 8'h00, 1'b0, "R5 poll during busy");
        wait_idle();
        check(busy_seen == PROG, "R5 busy length", busy_seen, PROG);
        ref_mem[30] = 8'hA0; ref_mem[31] = 8'hA1; ref_mem[0] = 8'hA2; ref_mem[1] = 8'hA3;
        read_run(30, 5, "R4 R9 written page read");

        // R2: foreign type is ignored, pointer kept
        send(2'd0, IDT, 16'h0000, 8'h00, 1'b1, 8'h00, 1'b0, "R2 own addr");
        send(2'd0, MAINT, 16'h0010, 8'h00, 1'b0, 8'h00, 1'b0, "R2 foreign addr");
        check(rsp_valid == 1'b0, "R2 no response to foreign type", 32'(rsp_valid), 0);
        send(2'd1, MAINT, 16'h0, 8'h5A, 1'b0, 8'h00, 1'b0, "R2 foreign data");
        check(rsp_valid == 1'b0, "R2 no response to foreign data", 32'(rsp_valid), 0);
        pulse_start();
        send(2'd2, IDT, 16'h0, 8'h00, 1'b1, ref_mem[0], 1'b1, "R2 pointer kept");
        pulse_stop();
        check(busy == 1'b0, "R2 foreign data staged nothing", 32'(busy), 0);

        // R8: probe while unlocked, then discarded by Start
        send(2'd0, IDT, 16'h0005, 8'h00, 1'b1, 8'h00, 1'b0, "R8 probe addr");
        send(2'd1, IDT, 16'h0, 8'h55, 1'b1, 8'h00, 1'b0, "R8 probe unlocked ack");
        pulse_start();
        pulse_stop();
        check(busy == 1'b0, "R8 probe programs nothing", 32'(busy), 0);
        read_run(5, 1, "R8 probe byte not written");

        // R6: lock with bit 1 clear has no effect
        send(2'd0, IDT, 16'h0400, 8'h00, 1'b1, 8'h00, 1'b0, "R6 lock addr");
        send(2'd1, IDT, 16'h0, 8'hFD, 1'b1, 8'h00, 1'b0, "R6 lock data bit1 clear");
        pulse_stop();
        check(busy == 1'b0 && locked == 1'b0, "R6 bit1 clear no lock", {busy, locked}, 0);

        // R4: a write still works while unlocked
        send(2'd0, IDT, 16'h0007, 8'h00, 1'b1, 8'h00, 1'b0, "R4 addr 7");
        send(2'd1, IDT, 16'h0, 8'h77, 1'b1, 8'h00, 1'b0, "R4 data 7");
        pulse_stop();
        wait_idle();
        ref_mem[7] = 8'h77;
        read_run(7, 1, "R4 byte 7");

        // R6: real lock
        send(2'd0, IDT, 16'hF400, 8'h00, 1'b1, 8'h00, 1'b0, "R6 lock addr");
        send(2'd1, IDT, 16'h0, 8'h02, 1'b1, 8'h00, 1'b0, "R6 lock data");
        pulse_stop();
        check(locked == 1'b0, "R6 lock waits for interval", 32'(locked), 0);
        wait_idle();
        check(busy_seen == PROG, "R5 lock busy length", busy_seen, PROG);
        check(locked == 1'b1, "R6 locked after interval", 32'(locked), 1);

        // R7 R8: probe while locked is refused; contents kept
        send(2'd0, IDT, 16'h0007, 8'h00, 1'b1, 8'h00, 1'b0, "R7 addr");
        send(2'd1, IDT, 16'h0, 8'h99, 1'b0, 8'h00, 1'b0, "R7 R8 locked data nack");
        pulse_stop();
        check(busy == 1'b0, "R7 nothing programmed", 32'(busy), 0);
        read_run(7, 1, "R7 contents kept");

        // R10: lock command with zero data and sessions do not clear it
        send(2'd0, IDT, 16'h0400, 8'h00, 1'b1, 8'h00, 1'b0, "R10 lock addr");
        send(2'd1, IDT, 16'h0, 8'h00, 1'b1, 8'h00, 1'b0, "R10 lock data zero");
        pulse_start();
        pulse_stop();
        check(locked == 1'b1, "R10 still locked", 32'(locked), 1);

        // R1 R10: power-on reset restores a fresh part
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(locked == 1'b0, "R10 reset clears lock", 32'(locked), 0);
        for (int i = 0; i < 32; i++) ref_mem[i] = 8'hFF;
        read_run(30, 2, "R1 page erased after reset");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 every event answered", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule